// File: doc/BRIEF.md
# Programmable Flag Offset Register Unit

This unit owns the two thresholds that a FIFO's programmable flags compare against: the empty-side offset and the full-side offset. Both live in the write clock domain and are driven out continuously to the flag logic. A master reset loads both offsets with one of two defaults. The level of the `ld` input during that reset picks the default and also fixes how the offsets may be changed afterwards: either one bit at a time over a serial input, or a whole word at a time from the data bus. The `ser_in` input is sampled during master reset as the first-word-fall-through mode bit. After reset the same pin carries the serial offset data.

In the parallel method, each write clock edge with `ld` and `wen` high stores `din` into one offset register. A two-state selector, `SEL_EMPTY` then `SEL_FULL`, picks the register. Each access moves `SEL_EMPTY` to `SEL_FULL`, and the next access moves `SEL_FULL` back to `SEL_EMPTY`. A second selector of the same shape, clocked by the read clock, steps on each `ld` and `ren` edge. It copies the chosen offset into the output register `dout`.

In the serial method, a fill machine places one bit per write clock edge while `sen` is high. In state `SER_EMPTY_BITS` it fills the empty offset, least significant bit first. After the last bit of that offset it moves to `SER_FULL_BITS` and fills the full offset. After the last bit there it returns to `SER_EMPTY_BITS`. A partial reset returns all three machines to their first state and clears `dout`. It keeps the offsets, the method and the mode bit. While `ld` is high, the unit blocks the FIFO memory write and read strobes.

Top module: `flag_offset_prog`

## Requirements
- R1: On a write clock edge with `mst_rst` high, both offsets take DEF_LARGE (1023) and the parallel method is selected (`par_mode`=1) if `ld` is high. Otherwise both offsets take DEF_SMALL (127) and the serial method is selected (`par_mode`=0). `dout` becomes zero.
- R2: The value of `ser_in` during master reset appears on `ft_mode` and stays there until the next master reset.
- R3: In the parallel method, a write clock edge with `ld` and `wen` high stores `din` into the empty offset if the write selector is in `SEL_EMPTY`, or into the full offset if it is in `SEL_FULL`. It then moves the selector to the other state.
- R4: After master or partial reset, parallel writes go to the empty offset, then the full offset, then the empty offset again.
- R5: A read clock edge with `ld` and `ren` high loads `dout` with the empty offset, the full offset, the empty offset, and so on in turn. On every other edge outside reset, `dout` holds its value.
- R6: In the serial method, each write clock edge with `sen` high stores `ser_in` into one bit and leaves all other bits unchanged. The first OFS_W bits go to the empty offset, bit 0 first. The next OFS_W bits go to the full offset, bit 0 first. The bit after that goes to bit 0 of the empty offset again.
- R7: In the serial method, `ld` with `wen` changes no offset. In the parallel method, `sen` changes no offset.
- R8: A partial reset keeps both offsets, `par_mode` and `ft_mode`. It clears `dout` and returns the write selector, the read selector and the serial bit position to their first state.
- R9: `mem_wen` follows `wen` and `mem_ren` follows `ren` while `ld` is low. Both are low while `ld` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; offset updates and resets |
| rd_clk | input | 1 | Read clock; readback selector and output register |
| mst_rst | input | 1 | Synchronous master reset, active high |
| part_rst | input | 1 | Synchronous partial reset, active high |
| ld | input | 1 | Offset access select; default/method select during master reset |
| wen | input | 1 | Write enable |
| ren | input | 1 | Read enable |
| sen | input | 1 | Serial load enable |
| ser_in | input | 1 | Serial offset data; mode bit during master reset |
| din | input | OFS_W | Parallel offset data |
| dout | output | OFS_W | Offset readback register |
| empty_ofs | output | OFS_W | Current empty-side offset |
| full_ofs | output | OFS_W | Current full-side offset |
| par_mode | output | 1 | 1 = parallel method, 0 = serial method |
| ft_mode | output | 1 | Mode bit latched at master reset |
| mem_wen | output | 1 | FIFO memory write strobe, blocked by `ld` |
| mem_ren | output | 1 | FIFO memory read strobe, blocked by `ld` |

## Verification
The case that is hardest to reach from the ports is a partial reset that arrives in the middle of a serial fill. At that point the bit position is hidden and the offsets already hold a mix of old and new bits. The stimulus wraps the fill one bit past the full offset and then issues a partial reset. It then shifts in a single 1. That 1 lands on bit 0 only if the position was cleared; without the restart it would land on a bit that already holds 1. A fill interrupted halfway through the full offset, with `ser_in` toggling while `sen` is low, shows that bits are stored one at a time.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } sel_e;

    typedef enum logic {
        SER_EMPTY_BITS = 1'b0,
        SER_FULL_BITS  = 1'b1
    } ser_e;

    typedef enum logic {
        METH_SERIAL   = 1'b0,
        METH_PARALLEL = 1'b1
    } meth_e;

endpackage

// File: rtl/ofs_sel_fsm.sv
module ofs_sel_fsm
    import ofs_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic step,
    output logic hit_empty,
    output logic hit_full
);

    sel_e state;
    sel_e state_nxt;

    always_ff @(posedge clk) begin
        if (clr) state <= SEL_EMPTY;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEL_EMPTY: if (step) state_nxt = SEL_FULL;
            SEL_FULL:  if (step) state_nxt = SEL_EMPTY;
        endcase
    end

    always_comb begin
        hit_empty = 1'b0;
        hit_full  = 1'b0;
        unique case (state)
            SEL_EMPTY: hit_empty = step;
            SEL_FULL:  hit_full  = step;
        endcase
    end

    // R3
    sel_advance_chk: assert property (@(posedge clk) disable iff (clr)
        (step && state == SEL_EMPTY) |=> (state == SEL_FULL));

    // R4
    sel_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        (step && state == SEL_FULL) |=> (state == SEL_EMPTY));

endmodule

// File: rtl/ofs_ser_fsm.sv
module ofs_ser_fsm
    import ofs_pkg::*;
#(
    parameter int W = 12,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             shift,
    output logic             bit_we,
    output logic             to_full,
    output logic [IDX_W-1:0] pos
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(W - 1);

    ser_e             state;
    ser_e             state_nxt;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_nxt;

    always_ff @(posedge clk) begin
        if (clr) begin
            state <= SER_EMPTY_BITS;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            idx   <= idx_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        idx_nxt   = idx;
        if (shift) begin
            if (idx == LAST) begin
                idx_nxt = '0;
                unique case (state)
                    SER_EMPTY_BITS: state_nxt = SER_FULL_BITS;
                    SER_FULL_BITS:  state_nxt = SER_EMPTY_BITS;
                endcase
            end else begin
                idx_nxt = idx + 1'b1;
            end
        end
    end

    always_comb begin
        bit_we  = shift;
        pos     = idx;
        to_full = 1'b0;
        unique case (state)
            SER_EMPTY_BITS: to_full = 1'b0;
            SER_FULL_BITS:  to_full = 1'b1;
        endcase
    end

    // R6
    ser_idx_range_chk: assert property (@(posedge clk) disable iff (clr)
        idx <= LAST);

    // R6
    ser_switch_chk: assert property (@(posedge clk) disable iff (clr)
        (shift && idx == LAST) |=> (idx == '0 && state != $past(state)));

endmodule

// File: rtl/flag_offset_prog.sv
module flag_offset_prog
    import ofs_pkg::*;
#(
    parameter int OFS_W     = 12,
    parameter int DEF_SMALL = 127,
    parameter int DEF_LARGE = 1023,
    localparam int IDX_W = (OFS_W > 1) ? $clog2(OFS_W) : 1
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mst_rst,
    input  logic             part_rst,
    input  logic             ld,
    input  logic             wen,
    input  logic             ren,
    input  logic             sen,
    input  logic             ser_in,
    input  logic [OFS_W-1:0] din,
    output logic [OFS_W-1:0] dout,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs,
    output logic             par_mode,
    output logic             ft_mode,
    output logic             mem_wen,
    output logic             mem_ren
);

    localparam logic [OFS_W-1:0] SMALL_V = OFS_W'(DEF_SMALL);
    localparam logic [OFS_W-1:0] LARGE_V = OFS_W'(DEF_LARGE);

    meth_e            meth_r;
    logic             ft_r;
    logic [OFS_W-1:0] empty_r;
    logic [OFS_W-1:0] full_r;
    logic [OFS_W-1:0] dout_r;

    logic             any_rst;
    logic             par_go;
    logic             ser_go;
    logic             rd_go;
    logic             w_hit_e;
    logic             w_hit_f;
    logic             r_hit_e;
    logic             r_hit_f;
    logic             s_we;
    logic             s_full;
    logic [IDX_W-1:0] s_pos;

    always_comb begin
        any_rst = mst_rst | part_rst;
        par_go  = ld & wen & (meth_r == METH_PARALLEL);
        ser_go  = sen & (meth_r == METH_SERIAL);
        rd_go   = ld & ren;
    end

    ofs_sel_fsm u_wsel (
        .clk       (wr_clk),
        .clr       (any_rst),
        .step      (par_go),
        .hit_empty (w_hit_e),
        .hit_full  (w_hit_f)
    );

    ofs_ser_fsm #(.W(OFS_W)) u_ser (
        .clk     (wr_clk),
        .clr     (any_rst),
        .shift   (ser_go),
        .bit_we  (s_we),
        .to_full (s_full),
        .pos     (s_pos)
    );

    ofs_sel_fsm u_rsel (
        .clk       (rd_clk),
        .clr       (any_rst),
        .step      (rd_go),
        .hit_empty (r_hit_e),
        .hit_full  (r_hit_f)
    );

    // Offset storage, method and mode bit: write clock domain
    always_ff @(posedge wr_clk) begin
        if (mst_rst) begin
            meth_r  <= ld ? METH_PARALLEL : METH_SERIAL;
            ft_r    <= ser_in;
            empty_r <= ld ? LARGE_V : SMALL_V;
            full_r  <= ld ? LARGE_V : SMALL_V;
        end else if (!part_rst) begin
            if (w_hit_e) empty_r <= din;
            if (w_hit_f) full_r  <= din;
            if (s_we) begin
                if (s_full) full_r[s_pos]  <= ser_in;
                else        empty_r[s_pos] <= ser_in;
            end
        end
    end

    // Readback register: read clock domain
    always_ff @(posedge rd_clk) begin
        if (any_rst)      dout_r <= '0;
        else if (r_hit_e) dout_r <= empty_r;
        else if (r_hit_f) dout_r <= full_r;
    end

    always_comb begin
        dout      = dout_r;
        empty_ofs = empty_r;
        full_ofs  = full_r;
        par_mode  = (meth_r == METH_PARALLEL);
        ft_mode   = ft_r;
        mem_wen   = wen & ~ld;
        mem_ren   = ren & ~ld;
    end

    // R8
    part_keep_chk: assert property (@(posedge wr_clk) disable iff (mst_rst)
        part_rst |=> ($stable(empty_r) && $stable(full_r) && $stable(meth_r) && $stable(ft_r)));

    // R7
    serial_blocks_par_chk: assert property (@(posedge wr_clk) disable iff (mst_rst)
        (meth_r == METH_SERIAL && !sen && !part_rst) |=> ($stable(empty_r) && $stable(full_r)));

    // R7
    par_blocks_serial_chk: assert property (@(posedge wr_clk) disable iff (mst_rst)
        (meth_r == METH_PARALLEL && !(ld && wen) && !part_rst) |=> ($stable(empty_r) && $stable(full_r)));

    // R5
    dout_hold_chk: assert property (@(posedge rd_clk) disable iff (mst_rst)
        (!part_rst && !(ld && ren)) |=> $stable(dout_r));

    // R2
    mode_hold_chk: assert property (@(posedge wr_clk) disable iff (mst_rst)
        1'b1 |=> $stable(ft_r));

endmodule

// File: tb/sim_flag_offset_prog.sv
module sim_flag_offset_prog;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         mst_rst = 1'b1;
    logic         part_rst = 1'b0;
    logic         ld = 1'b0;
    logic         wen = 1'b0;
    logic         ren = 1'b0;
    logic         sen = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic [W-1:0] empty_ofs;
    logic [W-1:0] full_ofs;
    logic         par_mode;
    logic         ft_mode;
    logic         mem_wen;
    logic         mem_ren;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [W-1:0] exp_q[$];

    always #5 clk = ~clk;

    flag_offset_prog #(.OFS_W(W)) u0 (
        .wr_clk(clk), .rd_clk(clk), .mst_rst(mst_rst), .part_rst(part_rst),
        .ld(ld), .wen(wen), .ren(ren), .sen(sen), .ser_in(ser_in), .din(din),
        .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .par_mode(par_mode), .ft_mode(ft_mode), .mem_wen(mem_wen), .mem_ren(mem_ren)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic mreset(input logic ldv, input logic siv);
        ld = ldv; ser_in = siv; mst_rst = 1'b1;
        tick(); tick();
        mst_rst = 1'b0; ld = 1'b0; ser_in = 1'b0;
    endtask

    task automatic preset();
        part_rst = 1'b1; tick(); part_rst = 1'b0;
    endtask

    task automatic pwrite(input logic [W-1:0] v);
        ld = 1'b1; wen = 1'b1; din = v; tick(); ld = 1'b0; wen = 1'b0;
    endtask

    task automatic pread(input logic [W-1:0] expv);
        exp_q.push_back(expv);
        ld = 1'b1; ren = 1'b1; tick(); ld = 1'b0; ren = 1'b0;
    endtask

    task automatic sshift(input logic [W-1:0] bits, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            sen = 1'b1; ser_in = bits[i]; tick();
        end
        sen = 1'b0; ser_in = 1'b0;
    endtask

    // Monitor: compares readback results against the scoreboard queue (R5)
    always @(posedge clk) begin
        if (!mst_rst && !part_rst && ld && ren) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                chk("R5 unexpected readback", 32'(dout), 32'hFFFF_FFFF);
            end else begin
                chk("R5 readback", 32'(dout), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    localparam logic [W-1:0] SE = 12'h5A3;
    localparam logic [W-1:0] SF = 12'h1C6;

    initial begin
        tick();
        // R1 R2: parallel default
        mreset(1'b1, 1'b1);
        chk("R1 empty default large", 32'(empty_ofs), 1023);
        chk("R1 full default large", 32'(full_ofs), 1023);
        chk("R1 parallel method", 32'(par_mode), 1);
        chk("R1 dout zero", 32'(dout), 0);
        chk("R2 ft_mode high", 32'(ft_mode), 1);

        // R9 strobes blocked while ld high
        ld = 1'b1; wen = 1'b1; ren = 1'b1; #1;
        chk("R9 mem_wen blocked", 32'(mem_wen), 0);
        chk("R9 mem_ren blocked", 32'(mem_ren), 0);
        ld = 1'b0; wen = 1'b0; ren = 1'b0;
        tick();

        // R3 R4 parallel writes
        pwrite(12'd100);
        chk("R3 empty written", 32'(empty_ofs), 100);
        chk("R3 full untouched", 32'(full_ofs), 1023);
        pwrite(12'd200);
        chk("R3 full written", 32'(full_ofs), 200);
        pwrite(12'd300);
        chk("R4 wrap to empty", 32'(empty_ofs), 300);
        chk("R4 full kept", 32'(full_ofs), 200);
        pwrite(12'd400);
        chk("R4 full second", 32'(full_ofs), 400);

        // R5 readback sequence with wrap
        pread(12'd300);
        pread(12'd400);
        pread(12'd300);
        tick(); tick();
        chk("R5 dout holds", 32'(dout), 300);

        // R7 sen ignored in parallel method
        sshift(12'hFFF, 0, 3);
        chk("R7 sen ignored empty", 32'(empty_ofs), 300);
        chk("R7 sen ignored full", 32'(full_ofs), 400);

        // R8 partial reset
        preset();
        chk("R8 empty kept", 32'(empty_ofs), 300);
        chk("R8 full kept", 32'(full_ofs), 400);
        chk("R8 method kept", 32'(par_mode), 1);
        chk("R8 ft kept", 32'(ft_mode), 1);
        chk("R8 dout cleared", 32'(dout), 0);
        pwrite(12'd555);
        chk("R8 write selector restart", 32'(empty_ofs), 555);
        chk("R8 full after restart", 32'(full_ofs), 400);
        pread(12'd555); // R8 read selector restart

        // R9 strobes pass while ld low; offsets untouched
        wen = 1'b1; ren = 1'b1; #1;
        chk("R9 mem_wen pass", 32'(mem_wen), 1);
        chk("R9 mem_ren pass", 32'(mem_ren), 1);
        tick();
        wen = 1'b0; ren = 1'b0;
        chk("R9 no offset change", 32'(empty_ofs), 555);
        chk("R9 dout unchanged", 32'(dout), 555);

        // R1 R2: serial default
        mreset(1'b0, 1'b0);
        chk("R1 empty default small", 32'(empty_ofs), 127);
        chk("R1 full default small", 32'(full_ofs), 127);
        chk("R1 serial method", 32'(par_mode), 0);
        chk("R2 ft_mode low", 32'(ft_mode), 0);

        // R7 parallel write ignored in serial method
        pwrite(12'd77);
        pwrite(12'd88);
        chk("R7 par ignored empty", 32'(empty_ofs), 127);
        chk("R7 par ignored full", 32'(full_ofs), 127);

        // R6 serial fill
        sshift(SE, 0, W);
        chk("R6 empty filled", 32'(empty_ofs), 32'(SE));
        chk("R6 full untouched", 32'(full_ofs), 127);
        sshift(SF, 0, 6);
        chk("R6 full partial", 32'(full_ofs), 32'h046);
        for (int i = 0; i < 4; i++) begin
            ser_in = ~ser_in; tick();
        end
        ser_in = 1'b0;
        chk("R6 no change sen low", 32'(full_ofs), 32'h046);
        sshift(SF, 6, 6);
        chk("R6 full filled", 32'(full_ofs), 32'(SF));
        sshift(12'h000, 0, 1);
        chk("R6 wrap to empty bit0", 32'(empty_ofs), 32'(SE & 12'hFFE));

        // R8 serial position restart
        preset();
        sshift(12'h001, 0, 1);
        chk("R8 serial pos restart", 32'(empty_ofs), 32'(SE));

        // R5 readback in serial method
        pread(SE);
        pread(SF);
        tick();
        chk("R5 queue drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule